// File: doc/BRIEF.md
# Triple-Redundant Scrubbed Memory

This block is a small word-addressable memory that survives single-event upsets. The storage is held three times over, in three identical register arrays. Every array has two ports. The user port serves writes and reads for the surrounding logic. The second port belongs to a background scrubber. It walks through every address, votes the three stored copies bit by bit, and writes the voted word back into all three arrays. A corrupted word in one array is therefore repaired within one sweep, well before a second upset can land on the same address.

Every user read returns the bitwise majority of the three arrays, so a single damaged copy is never visible at the output. A mismatch output goes high for as long as the three copies at the user address disagree. The scrubber's address counter is also held in three copies. Each copy reloads from the voted count plus one, so a disturbed copy rejoins the other two on the next clock. When the user port and the scrubber touch the same word, the user write always wins.

Top module: `tmr_scrub_mem`

## Requirements
- R1: While reset is asserted, every location of all three arrays is cleared to zero and the scrub address is set to 0. After reset, a read of any address returns 0 with the mismatch output low.
- R2: A write on the user port (`usr_we` high at a rising clock edge) stores `usr_wdata` at `usr_addr` in all three arrays. From the next cycle on, a read of that address returns the written word.
- R3: `usr_rdata` is the bitwise majority of the three arrays at `usr_addr`, and reads are combinational. A word that is corrupted in any single array still reads back correctly.
- R4: `usr_mismatch` is high exactly when the three array words at `usr_addr` are not all equal. When it is low, `usr_rdata` equals every copy.
- R5: The voted scrub address advances by one on every clock after reset and wraps from DEPTH-1 to 0.
- R6: If one copy of the scrub counter differs from the others, all three copies agree again one clock later.
- R7: A word corrupted in one array is rewritten with the voted value within DEPTH+2 clocks, with no user action. After that, the mismatch output stays low for that address.
- R8: A user write is never lost to the scrubber. This holds when the user writes the word that the scrubber reads in the same cycle, and when the user writes the word that the scrubber writes back in the same cycle.
- R9: A scrub write-back happens one cycle after the read: the address written back in a cycle equals the voted scrub address of the previous cycle.
- R10: Upsets in two different arrays that hit different bits of the same word are masked on read and are repaired by the scrubber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all three arrays and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_we | input | 1 | User write strobe |
| usr_addr | input | $clog2(DEPTH) | User word address for reads and writes |
| usr_wdata | input | DW | User write data |
| usr_rdata | output | DW | Bitwise-majority read data at `usr_addr` |
| usr_mismatch | output | 1 | High while the three copies at `usr_addr` differ |

## Verification
The bench builds the block with its default parameters: 8-bit words and 16 locations. With 16 locations a full scrub sweep takes only a few clocks, so tests can wait for one repair after another. Two descending write sweeps, run one cycle out of phase, make the user address cross the ascending scrub address at both even and odd offsets. That reaches both the read-cycle collision and the write-back collision. Upsets are deposited straight into single array words and into one counter copy, so the masking, mismatch, repair and counter-recovery paths are all reached.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;
  localparam int NCOPY = 3;

  // address bits needed for a given word count (at least one)
  function automatic int addr_bits(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         differ
);
  always_comb begin
    y      = (a & b) | (a & c) | (b & c);
    differ = (a != b) || (b != c);
  end
endmodule

// File: rtl/tmr_scrub_ctr.sv
module tmr_scrub_ctr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] voted,
  output logic [AW-1:0] count
);
  logic [AW-1:0] cnt_q;

  // reload from the voted value so a disturbed copy rejoins the others
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= voted + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tmr_scrub_array.sv
module tmr_scrub_array #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  // user port
  input  logic          u_we,
  input  logic [AW-1:0] u_addr,
  input  logic [DW-1:0] u_wdata,
  output logic [DW-1:0] u_rdata,
  // scrub port
  input  logic [AW-1:0] s_raddr,
  output logic [DW-1:0] s_rdata,
  input  logic          s_we,
  input  logic [AW-1:0] s_waddr,
  input  logic [DW-1:0] s_wdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (s_we) mem[s_waddr] <= s_wdata;
      // user port written last: it wins on a shared address
      if (u_we) mem[u_addr]  <= u_wdata;
    end
  end

  assign u_rdata = mem[u_addr];
  assign s_rdata = mem[s_raddr];
endmodule

// File: rtl/tmr_scrub_mem.sv
module tmr_scrub_mem
  import tmr_scrub_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_we,
  input  logic [AW-1:0] usr_addr,
  input  logic [DW-1:0] usr_wdata,
  output logic [DW-1:0] usr_rdata,
  output logic          usr_mismatch
);
  logic [AW-1:0] cnt_c  [NCOPY];
  logic [AW-1:0] cnt_v  [NCOPY];
  logic [DW-1:0] rd_u   [NCOPY];
  logic [DW-1:0] rd_s   [NCOPY];
  logic [DW-1:0] scr_v  [NCOPY];
  logic [DW-1:0] wb_data[NCOPY];
  logic [AW-1:0] wb_addr[NCOPY];
  logic          wb_ok  [NCOPY];
  logic          scr_we [NCOPY];

  genvar k;
  generate
    for (k = 0; k < NCOPY; k++) begin : g_copy
      logic cnt_diff;
      logic scr_diff;

      // each domain votes the counter on its own
      tmr_vote #(.W(AW)) u_cnt_vote (
        .a(cnt_c[0]), .b(cnt_c[1]), .c(cnt_c[2]),
        .y(cnt_v[k]), .differ(cnt_diff)
      );

      tmr_scrub_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .voted(cnt_v[k]), .count(cnt_c[k])
      );

      // each domain votes the scrub read data
      tmr_vote #(.W(DW)) u_scr_vote (
        .a(rd_s[0]), .b(rd_s[1]), .c(rd_s[2]),
        .y(scr_v[k]), .differ(scr_diff)
      );

      // read stage -> write-back stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wb_data[k] <= '0;
          wb_addr[k] <= '0;
          wb_ok[k]   <= 1'b0;
        end else begin
          wb_data[k] <= scr_v[k];
          wb_addr[k] <= cnt_v[k];
          // a user write in the read cycle makes the voted word stale
          wb_ok[k]   <= !(usr_we && (usr_addr == cnt_v[k]));
        end
      end

      assign scr_we[k] = wb_ok[k] && !(usr_we && (usr_addr == wb_addr[k]));

      tmr_scrub_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .u_we(usr_we), .u_addr(usr_addr), .u_wdata(usr_wdata), .u_rdata(rd_u[k]),
        .s_raddr(cnt_v[k]), .s_rdata(rd_s[k]),
        .s_we(scr_we[k]), .s_waddr(wb_addr[k]), .s_wdata(wb_data[k])
      );
    end
  endgenerate

  tmr_vote #(.W(DW)) u_usr_vote (
    .a(rd_u[0]), .b(rd_u[1]), .c(rd_u[2]),
    .y(usr_rdata), .differ(usr_mismatch)
  );

  // named views for the checker
  logic [AW-1:0] cnt_c0, cnt_c1, cnt_c2, cnt_vote, wb_addr_vote;
  logic [DW-1:0] rd_u0, rd_u1, rd_u2;
  logic          wb_addr_diff;
  assign cnt_c0   = cnt_c[0];
  assign cnt_c1   = cnt_c[1];
  assign cnt_c2   = cnt_c[2];
  assign cnt_vote = cnt_v[0];
  assign rd_u0    = rd_u[0];
  assign rd_u1    = rd_u[1];
  assign rd_u2    = rd_u[2];

  tmr_vote #(.W(AW)) u_wb_addr_vote (
    .a(wb_addr[0]), .b(wb_addr[1]), .c(wb_addr[2]),
    .y(wb_addr_vote), .differ(wb_addr_diff)
  );
endmodule

// File: rtl/tmr_scrub_mem_chk.sv
module tmr_scrub_mem_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          usr_we,
  input logic [AW-1:0] usr_addr,
  input logic [DW-1:0] usr_wdata,
  input logic [DW-1:0] usr_rdata,
  input logic          usr_mismatch,
  input logic [AW-1:0] cnt_c0,
  input logic [AW-1:0] cnt_c1,
  input logic [AW-1:0] cnt_c2,
  input logic [AW-1:0] cnt_vote,
  input logic [AW-1:0] wb_addr_vote,
  input logic [DW-1:0] rd_u0,
  input logic [DW-1:0] rd_u1,
  input logic [DW-1:0] rd_u2
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (cnt_vote == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    usr_we |=> (usr_addr != $past(usr_addr)) ||
               (rd_u0 == $past(usr_wdata) && rd_u1 == $past(usr_wdata) &&
                rd_u2 == $past(usr_wdata)));

  assert_single_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_u0 == rd_u1) |-> (usr_rdata == rd_u0));

  assert_clean_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !usr_mismatch |-> (usr_rdata == rd_u0 && rd_u1 == rd_u0 && rd_u2 == rd_u0));

  assert_scrub_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt_vote == AW'($past(cnt_vote) + 1'b1)));

  assert_ctr_heal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_c0 != cnt_c1 || cnt_c1 != cnt_c2) |=>
      (cnt_c0 == cnt_c1 && cnt_c1 == cnt_c2));

  assert_wb_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (wb_addr_vote == $past(cnt_vote)));
endmodule

bind tmr_scrub_mem tmr_scrub_mem_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .usr_we(usr_we), .usr_addr(usr_addr),
  .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_mismatch(usr_mismatch),
  .cnt_c0(cnt_c0), .cnt_c1(cnt_c1), .cnt_c2(cnt_c2), .cnt_vote(cnt_vote),
  .wb_addr_vote(wb_addr_vote), .rd_u0(rd_u0), .rd_u1(rd_u1), .rd_u2(rd_u2)
);

// File: tb/tmr_scrub_mem_bench.sv
module tmr_scrub_mem_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          usr_we;
  logic [AW-1:0] usr_addr;
  logic [DW-1:0] usr_wdata;
  logic [DW-1:0] usr_rdata;
  logic          usr_mismatch;

  always #5 clk = ~clk;

  tmr_scrub_mem #(.DW(DW), .DEPTH(DEPTH)) u_tmr_scrub_mem (
    .clk(clk), .rst_n(rst_n), .usr_we(usr_we), .usr_addr(usr_addr),
    .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_mismatch(usr_mismatch)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          mm;
    string         req;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] model [DEPTH];
  int            n_chk  = 0;
  int            n_fail = 0;
  bit            done   = 1'b0;

  // monitor: pops expectations mid-cycle, after the driver has set the address
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (usr_rdata !== e.data || usr_mismatch !== e.mm) begin
          n_fail++;
          $display("FAIL %s: rdata=%h mismatch=%b expected rdata=%h mismatch=%b",
                   e.req, usr_rdata, usr_mismatch, e.data, e.mm);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    usr_we = 1'b1; usr_addr = a; usr_wdata = d;
    model[a] = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      usr_we = 1'b0;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic mm, input string req);
    exp_t e;
    @(negedge clk);
    usr_we = 1'b0; usr_addr = a;
    e.data = model[a]; e.mm = mm; e.req = req;
    sb_q.push_back(e);
  endtask

  // deposit an upset into one array copy (called right after a negedge)
  task automatic upset(input int copy, input logic [AW-1:0] a, input logic [DW-1:0] flip);
    case (copy)
      0: u_tmr_scrub_mem.g_copy[0].u_arr.mem[a] = u_tmr_scrub_mem.g_copy[0].u_arr.mem[a] ^ flip;
      1: u_tmr_scrub_mem.g_copy[1].u_arr.mem[a] = u_tmr_scrub_mem.g_copy[1].u_arr.mem[a] ^ flip;
      default: u_tmr_scrub_mem.g_copy[2].u_arr.mem[a] = u_tmr_scrub_mem.g_copy[2].u_arr.mem[a] ^ flip;
    endcase
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; usr_we = 1'b0; usr_addr = '0; usr_wdata = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every location reads zero after reset
    for (int i = 0; i < DEPTH; i++) rd(AW'(i), 1'b0, "R1 reset clear");

    // R2: write then read, several patterns
    wr(4'd3, 8'hA5); rd(4'd3, 1'b0, "R2 write/read");
    wr(4'd0, 8'hFF); wr(4'd15, 8'h01); rd(4'd0, 1'b0, "R2 low address");
    rd(4'd15, 1'b0, "R2 high address");
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), DW'(i * 17 + 9));
    for (int i = 0; i < DEPTH; i++) rd(AW'(i), 1'b0, "R2 full sweep");

    // R3/R4: single-copy upset masked, mismatch raised
    idle(2);
    @(negedge clk);
    upset(1, 4'd5, 8'h3C);
    usr_addr = 4'd5;
    begin exp_t e; e.data = model[5]; e.mm = 1'b1; e.req = "R3 R4 masked upset"; sb_q.push_back(e); end
    // R7: repaired by the scrubber within one sweep
    idle(DEPTH + 2);
    rd(4'd5, 1'b0, "R7 scrub repair");

    // R10: different bits upset in two copies
    idle(1);
    @(negedge clk);
    upset(0, 4'd9, 8'h01);
    upset(2, 4'd9, 8'h80);
    usr_addr = 4'd9;
    begin exp_t e; e.data = model[9]; e.mm = 1'b1; e.req = "R10 two-copy masked"; sb_q.push_back(e); end
    idle(DEPTH + 2);
    rd(4'd9, 1'b0, "R10 two-copy repaired");

    // R6: disturb one counter copy, scrubbing must keep working
    idle(1);
    @(negedge clk);
    u_tmr_scrub_mem.g_copy[1].u_ctr.cnt_q = u_tmr_scrub_mem.g_copy[1].u_ctr.cnt_q + 4'd7;
    upset(2, 4'd12, 8'hF0);
    idle(DEPTH + 3);
    rd(4'd12, 1'b0, "R6 R5 counter recovered, repair done");

    // R8: descending sweeps cross the ascending scrub address at both parities
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < DEPTH; i++) wr(AW'(DEPTH - 1 - i), DW'(8'h40 + p * 8'h20 + i * 3));
      idle(p + 1);
    end
    for (int i = 0; i < DEPTH; i++) rd(AW'(i), 1'b0, "R8 user write wins");

    // R8: hammer one address across a full sweep
    for (int i = 0; i < 2 * DEPTH; i++) wr(4'd7, DW'(i * 5 + 1));
    rd(4'd7, 1'b0, "R8 repeated writes");

    // R9: write-back lands one cycle later; upset followed by quiet sweep
    idle(1);
    @(negedge clk);
    upset(0, 4'd2, 8'hFF);
    idle(DEPTH + 2);
    rd(4'd2, 1'b0, "R9 write-back address");

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule